// File: doc/BRIEF.md
# Burst Pseudo-SRAM Byte-Lane Interface

This block is the device end of a synchronous burst pseudo-SRAM with a 16-bit data path split into two byte lanes. A host starts a read burst by pulling address-valid low together with chip enable on a clock edge. The block then waits a fixed initial latency, holding its WAIT output asserted, and streams one word per clock from consecutive addresses. Each byte lane has its own active-low enable that decides whether that lane is driven on reads and whether it is stored on writes. Writes are asynchronous-style windows (chip enable, write enable and at least one lane enable low), sampled on the clock, and commit the moment any of those controls returns high.

A hidden refresh engine, driven by a free-running timer, takes the array for a few cycles at a time. When a read starts while a refresh is running, or a refresh is still running when the latency count runs out, the first data beat is held back and WAIT stays asserted until the array is free. A refresh that falls due while a burst is already delivering data is held off until the data phase ends. A small on-chip array stands in for the memory core, and the bus is modelled as a data-out vector plus one output-enable bit per lane.

Top module: `psram_burst_if`

## Requirements
- R1: Lane 0 (`dq_o[7:0]`, `dq_oe[0]`) is governed by `lb_n` and lane 1 (`dq_o[15:8]`, `dq_oe[1]`) by `ub_n`, both active low. During the data phase of a read, a lane drives (its `dq_oe` bit is 1) only while its enable, `oe_n` and `ce_n` are all low. Otherwise the lane is high impedance (`dq_oe` bit 0).
- R2: A write stores only the lanes whose enables were low. A disabled lane keeps its previously stored byte.
- R3: A write window is open while `ce_n`, `we_n` and at least one lane enable are low. The word is committed on the first clock edge at which any of `ce_n`, `we_n` or an enabled lane's enable is seen high. The address, data and lanes used are those sampled on the previous edge. A window commits only once, until `ce_n` or `we_n` goes high.
- R4: When `lb_n` and `ub_n` are both high, nothing is driven and nothing is written. A running burst keeps advancing its address during such beats.
- R5: A burst starts on an edge with `ce_n`=0, `adv_n`=0 and `we_n`=1, capturing `addr`. With no refresh in the way, the first word appears after LAT_CODE+1 edges, counting the start edge as edge 0 (3 for the default code 2). Each later edge presents the next address.
- R6: `wait_n` is low from the start edge until the edge on which the first word appears, and high at all other times. It is never low while any lane drives.
- R7: A refresh starts on every edge whose count since reset release is a multiple of REF_PERIOD, unless a burst is in its data phase, in which case it waits. It occupies the array for REF_CYCLES edges. The first word of a burst appears no earlier than the edge after the refresh ends, so a burst starting on the same edge as a refresh delivers its first word after REF_CYCLES+1 edges.
- R8: While `ce_n` is high, `wait_n` is high and no lane drives, with no clock delay. The burst is ended and does not resume when `ce_n` returns low without a new start.
- R9: After reset, `wait_n` is high and no lane drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid / burst start, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Lower byte lane enable, active low |
| ub_n | input | 1 | Upper byte lane enable, active low |
| addr | input | AW | Word address |
| dq_i | input | 16 | Write data from the bus |
| dq_o | output | 16 | Read data to the bus |
| dq_oe | output | 2 | Per-lane bus drive enable |
| wait_n | output | 1 | Wait indication, active low |

## Verification
The latency count and a hidden refresh can run out on the same edge. This is the case where the first beat must be held back. The bench tracks refresh due times with its own count of edges from reset release and starts a read on exactly the edge a refresh begins. It then checks that `wait_n` is still low on the edges where an undisturbed read would already return data, and that the right word appears only on the edge after the refresh ends. A second read is placed well clear of any refresh due time to fix the undisturbed three-edge latency for comparison.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [1:0] {
    BST_IDLE = 2'd0,
    BST_LAT  = 2'd1,
    BST_DATA = 2'd2
  } bst_state_t;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/psram_refresh.sv
module psram_refresh #(
  parameter int unsigned PERIOD = 64,
  parameter int unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic busy
);
  localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int unsigned BW = $clog2(CYCLES + 1);

  logic [PW-1:0] tmr_q, tmr_d;
  logic [BW-1:0] left_q, left_d;
  logic          pend_q, pend_d;
  logic          expire, start;

  always_comb begin
    expire = (tmr_q == PW'(PERIOD - 1));
    start  = (expire || pend_q) && (left_q == '0) && !hold;
    tmr_d  = expire ? '0 : tmr_q + 1'b1;
    pend_d = start ? 1'b0 : (expire ? 1'b1 : pend_q);
    if (start)              left_d = BW'(CYCLES);
    else if (left_q != '0)  left_d = left_q - 1'b1;
    else                    left_d = left_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
      left_q <= '0;
    end else begin
      tmr_q  <= tmr_d;
      pend_q <= pend_d;
      left_q <= left_d;
    end
  end

  assign busy = (left_q != '0);

  // R7: a refresh never begins while a burst was delivering data
  assert_refresh_deferred_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!hold));
endmodule

// File: rtl/psram_write_capture.sv
module psram_write_capture #(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 2,
  localparam int unsigned DW   = LANES * psram_pkg::LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic [LANES-1:0] be_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  output logic             commit,
  output logic [AW-1:0]    waddr,
  output logic [DW-1:0]    wdata,
  output logic [LANES-1:0] wlane
);
  logic             open_q, open_d, done_q, done_d, win_act, load;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic [LANES-1:0] lane_q;

  always_comb begin
    win_act = !ce_n && !we_n && (|(~be_n)) && !done_q;
    commit  = open_q && (ce_n || we_n || (|(lane_q & be_n)));
    load    = win_act && !commit;
    open_d  = load;
    if (ce_n || we_n) done_d = 1'b0;
    else if (commit)  done_d = 1'b1;
    else              done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      open_q <= open_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      lane_q <= '0;
    end else if (load) begin
      addr_q <= addr;
      data_q <= din;
      lane_q <= ~be_n;
    end
  end

  assign waddr = addr_q;
  assign wdata = data_q;
  assign wlane = lane_q;

  // R3: every commit carries at least one lane taken from an open window
  assert_commit_has_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (wlane != '0));
endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl
  import psram_pkg::*;
#(
  parameter int unsigned AW  = 6,
  parameter int unsigned LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          ref_busy,
  output logic          data_phase,
  output logic          lat_phase,
  output logic [AW-1:0] baddr
);
  localparam int unsigned CW = $clog2(LAT + 1);

  bst_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] ad_q, ad_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ad_d  = ad_q;
    if (ce_n) begin
      st_d = BST_IDLE;
    end else if (!adv_n && we_n) begin
      st_d  = BST_LAT;
      cnt_d = CW'(1);
      ad_d  = addr;
    end else begin
      case (st_q)
        BST_LAT: begin
          if (cnt_q >= CW'(LAT) && !ref_busy) st_d = BST_DATA;
          else if (cnt_q < CW'(LAT))          cnt_d = cnt_q + 1'b1;
        end
        BST_DATA: ad_d = ad_q + 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BST_IDLE;
      cnt_q <= '0;
      ad_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ad_q  <= ad_d;
    end
  end

  assign data_phase = (st_q == BST_DATA);
  assign lat_phase  = (st_q == BST_LAT);
  assign baddr      = ad_q;

  // R5: the first beat never comes before the full latency count
  assert_latency_met_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_phase) |-> ($past(cnt_q) >= CW'(LAT)));
  // R5: consecutive beats step the word address by one
  assert_beat_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && $past(data_phase) && !$past(ce_n) && $past(adv_n))
      |-> (baddr == $past(baddr) + 1'b1));
endmodule

// File: rtl/psram_burst_if.sv
module psram_burst_if #(
  parameter int unsigned AW         = 6,
  parameter int unsigned LAT_CODE   = 2,
  parameter int unsigned REF_PERIOD = 64,
  parameter int unsigned REF_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          lb_n,
  input  logic          ub_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_i,
  output logic [15:0]   dq_o,
  output logic [1:0]    dq_oe,
  output logic          wait_n
);
  localparam int unsigned LANES = 2;
  localparam int unsigned LW    = psram_pkg::LANE_W;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned LAT   = LAT_CODE + 1;

  logic [LANES-1:0] be_n;
  logic             data_phase, lat_phase, ref_busy, commit;
  logic [AW-1:0]    baddr, waddr;
  logic [15:0]      wdata;
  logic [LANES-1:0] wlane;

  assign be_n = {ub_n, lb_n};

  psram_refresh #(.PERIOD(REF_PERIOD), .CYCLES(REF_CYCLES)) refresh_i (
    .clk(clk), .rst_n(rst_n), .hold(data_phase), .busy(ref_busy));

  psram_burst_ctrl #(.AW(AW), .LAT(LAT)) burst_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
    .addr(addr), .ref_busy(ref_busy), .data_phase(data_phase),
    .lat_phase(lat_phase), .baddr(baddr));

  psram_write_capture #(.AW(AW), .LANES(LANES)) wcap_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .be_n(be_n),
    .addr(addr), .din(dq_i), .commit(commit), .waddr(waddr),
    .wdata(wdata), .wlane(wlane));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem_q [DEPTH];
    always_ff @(posedge clk) begin
      if (commit && wlane[g]) mem_q[waddr] <= wdata[g*LW +: LW];
    end
    assign dq_o[g*LW +: LW] = data_phase ? mem_q[baddr] : '0;
    assign dq_oe[g] = data_phase && !ce_n && !oe_n && !be_n[g];
  end

  assign wait_n = !(lat_phase && !ce_n);

  // R1: the lower lane drives only with its own enable low
  assert_lane_lo_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[0] |-> (!lb_n && !oe_n));
  // R6: WAIT asserted and data driven never overlap
  assert_wait_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_n |-> (dq_oe == '0));
  // R7: first data only once the refresh has released the array
  assert_refresh_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_phase) |-> $past(!ref_busy));
  // R8: a deselected device neither waits nor drives
  assert_ce_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (wait_n && dq_oe == '0));
endmodule

// File: tb/psram_burst_if_tb.sv
module psram_burst_if_tb_top;
  localparam int CLK_P = 10;
  localparam int PER   = 64;

  logic        clk, rst_n, ce_n, adv_n, oe_n, we_n, lb_n, ub_n;
  logic [5:0]  addr;
  logic [15:0] dq_i, dq_o;
  logic [1:0]  dq_oe;
  logic        wait_n;
  int          checks, errors, cyc;
  bit          done;

  psram_burst_if #(.AW(6), .LAT_CODE(2), .REF_PERIOD(PER), .REF_CYCLES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
    .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe(dq_oe), .wait_n(wait_n));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_bus();
    ce_n = 1; adv_n = 1; we_n = 1; oe_n = 1; lb_n = 1; ub_n = 1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic [1:0] ln);
    ce_n = 0; we_n = 0; addr = a; dq_i = d; lb_n = !ln[0]; ub_n = !ln[1];
    tick();
    idle_bus();
    tick();
    tick();
  endtask

  task automatic wait_phase(input int ph);
    while ((cyc % PER) != ph) tick();
  endtask

  task automatic start_read(input logic [5:0] a);
    ce_n = 0; adv_n = 0; we_n = 1; oe_n = 0; lb_n = 0; ub_n = 0; addr = a;
    tick();
    adv_n = 1;
  endtask

  task automatic t_reset();
    #1;
    check("R9 wait_n", wait_n, 1'b1);
    check("R9 dq_oe", dq_oe, 2'b00);
  endtask

  task automatic t_writes();
    wr(6'd5, 16'hA1B2, 2'b11);
    wr(6'd6, 16'h1234, 2'b11);
    wr(6'd7, 16'h5678, 2'b11);
    wr(6'd8, 16'h0F0F, 2'b11);
    wr(6'd9, 16'hC3C3, 2'b11);
    wr(6'd11, 16'h4444, 2'b11);
    wr(6'd5, 16'hFFCC, 2'b01);   // R2 lower only
    wr(6'd6, 16'h9900, 2'b10);   // R2 upper only
    // R4 both lanes off: must not store
    ce_n = 0; we_n = 0; addr = 6'd11; dq_i = 16'h5555; lb_n = 1; ub_n = 1;
    tick(); tick();
    idle_bus(); tick();
    // R3 lower enable rises first: word from the prior edge, single commit
    ce_n = 0; we_n = 0; addr = 6'd10; dq_i = 16'h1111; lb_n = 0; ub_n = 0;
    tick();
    lb_n = 1; dq_i = 16'h2222;
    tick();
    dq_i = 16'h3333;
    tick(); tick();
    idle_bus(); tick(); tick();
  endtask

  task automatic t_burst();
    wait_phase(8);
    start_read(6'd5);
    #1 check("R6 wait low after start", wait_n, 1'b0);
    check("R6 no drive while waiting", dq_oe, 2'b00);
    tick(); tick();
    #1 check("R6 wait low before latency", wait_n, 1'b0);
    tick();
    #1 check("R5 first beat wait_n", wait_n, 1'b1);
    check("R5 first beat lanes", dq_oe, 2'b11);
    check("R2 lower masked write", dq_o, 16'hA1CC);
    tick();
    #1 check("R2 upper masked write", dq_o, 16'h9934);
    lb_n = 1;
    #1 check("R1 upper only drive", dq_oe, 2'b10);
    check("R1 upper lane data", dq_o[15:8], 8'h99);
    tick();
    ub_n = 1;
    #1 check("R4 both lanes off", dq_oe, 2'b00);
    tick();
    #1 check("R4 still off", dq_oe, 2'b00);
    lb_n = 0; ub_n = 0;
    #1 check("R4 address kept advancing", dq_o, 16'h0F0F);
    check("R1 both lanes drive", dq_oe, 2'b11);
    tick();
    #1 check("R5 next word", dq_o, 16'hC3C3);
    oe_n = 1;
    #1 check("R1 oe_n high no drive", dq_oe, 2'b00);
    oe_n = 0; ce_n = 1;
    #1 check("R8 ce_n high no drive", dq_oe, 2'b00);
    check("R8 ce_n high wait_n", wait_n, 1'b1);
    tick();
    ce_n = 0; adv_n = 1;
    tick(); tick();
    #1 check("R8 burst stays ended", dq_oe, 2'b00);
    check("R8 no wait after end", wait_n, 1'b1);
    idle_bus(); tick();
  endtask

  task automatic t_collision();
    tick(); tick();
    wait_phase(PER - 1);
    start_read(6'd10);
    tick(); tick(); tick();
    #1 check("R7 wait held past latency", wait_n, 1'b0);
    check("R7 no early data", dq_oe, 2'b00);
    tick();
    #1 check("R7 wait held in refresh", wait_n, 1'b0);
    tick();
    #1 check("R7 wait released", wait_n, 1'b1);
    check("R7 drive after refresh", dq_oe, 2'b11);
    check("R3 first-rise capture", dq_o, 16'h1111);
    tick();
    #1 check("R4 disabled write ignored", dq_o, 16'h4444);
    idle_bus(); tick();
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 0; addr = '0; dq_i = '0;
    idle_bus();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    tick();
    t_writes();
    t_burst();
    t_collision();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule